// File: doc/BRIEF.md
# Indexed Block-Transfer Serial Configuration Slave

This block is a two-wire serial bus slave that holds a sixteen-byte bank of configuration registers and drives their contents onto a flat parallel output for the surrounding logic. A host reaches the bank only through indexed block transfers. In a write, the host names a starting index and then a byte count, and the data bytes follow. In a read, the host first sends the index in a short write phase and then issues a repeated start with the read address. The slave answers with the value of its count register, followed by consecutive register bytes, until the host stops acknowledging.

The block runs on a single system clock. It samples the already-synchronized clock and data lines and looks for line edges as well as start and stop conditions. It pulls the data line low through an open-drain enable, and changes that enable only while the bus clock is low. Two strap inputs replace the low bits of the 7-bit slave address, so up to four such slaves can share one bus. Any start or stop condition resets the byte engine, including one that arrives in the middle of a byte.

Top module: `smbus_blk_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {BASE_ADDR[6:2], strap_i}. With the default base 7'h6A and strap_i = 2'b10 the write address byte is D4h and the read address byte is D5h. Bit 0 of the address byte is 0 for write and 1 for read.
- R2: When the address does not match, the slave never asserts sda_oe_o and ignores every later byte until the next start. No register changes.
- R3: In a block write (start, write address, index N, count X, data), the slave acknowledges the index, the count and each of the first X data bytes. It stores data byte k at index N+k.
- R4: Data bytes beyond the count X are not acknowledged and are not stored. The slave then ignores the bus until the next start or stop.
- R5: The register index wraps modulo 16. Only the low 4 bits of the index byte are used.
- R6: In a block read (start, write address, index N, repeated start, read address), the slave first sends the count register (index 8) and then bytes N, N+1, … MSB first. It continues while the host acknowledges and stops sending after the host's NACK.
- R7: A read that follows the read address directly after a start, with no index phase, begins at the last index value the host wrote.
- R8: Registers 14 and 15 are read-only and hold A0h|index (AEh and AFh). Writes to them are acknowledged but leave them unchanged.
- R9: After reset all writable registers are 00h, except the count register at index 8, which is 02h. sda_oe_o is 0.
- R10: sda_oe_o changes only while scl_i is low. A start or stop seen in the middle of a byte aborts the transfer without writing anything, releases SDA, and leaves the slave ready for the next transfer.
- R11: The count register at index 8 is writable by a block write, and the new value is the count returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level (wired-AND of all drivers) |
| strap_i | input | 2 | Low bits of the 7-bit slave address |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| regs_o | output | 128 | Register bank, byte i at bits [8i+7:8i] |

## Verification
The hardest states to reach are the aborted byte and the overrun byte. Each requires the host to break protocol at an exact bit position while the slave sits in its data phase with a partially filled shift register. The bench host model is bit-accurate and can stop after any number of bits or send more bytes than it announced. It issues a stop after three bits of a data byte, and it sends one byte past a count of one. It then reads the bank back, both through the bus and at the parallel outputs, to confirm that nothing was written. A read with no index phase is placed right after a write that moved the stored index, so that the starting point of the read is observable.

// File: rtl/smbus_blk_pkg.sv
package smbus_blk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK_SETUP,
        S_ACK_HOLD,
        S_TX,
        S_TX_ACK,
        S_TX_WAIT,
        S_IGNORE
    } bus_st_e;

    typedef enum logic [2:0] {
        P_ADDR,
        P_IDX,
        P_CNT,
        P_DATA,
        P_TXSTART
    } byte_ph_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

endpackage

// File: rtl/smbus_bus_cond.sv
module smbus_bus_cond
    import smbus_blk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    line_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
        scl_rise_o = !line_q.scl && scl_i;
        scl_fall_o = line_q.scl && !scl_i;
        start_o    = line_q.scl && scl_i && line_q.sda && !sda_i;
        stop_o     = line_q.scl && scl_i && !line_q.sda && sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{scl: 1'b1, sda: 1'b1};
        else        line_q <= line_d;
    end
endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank #(
    parameter int              REG_COUNT = 16,
    parameter int              IDX_W     = 4,
    parameter int              CNT_IDX   = 8,
    parameter logic [7:0]      CNT_RST   = 8'h02,
    parameter logic [REG_COUNT-1:0] RO_MASK = 16'hC000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [REG_COUNT*8-1:0] regs_o
);
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (RO_MASK[i]) begin : g_ro
            assign regs_o[i*8 +: 8] = 8'hA0 | 8'(i);
        end else begin : g_rw
            localparam logic [7:0] RST_V = (i == CNT_IDX) ? CNT_RST : 8'h00;
            logic [7:0] r_d, r_q;

            always_comb begin
                r_d = r_q;
                if (wr_en && wr_idx == IDX_W'(i)) r_d = wr_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= RST_V;
                else        r_q <= r_d;
            end

            assign regs_o[i*8 +: 8] = r_q;

            // R3
            wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && wr_idx == IDX_W'(i) |=> r_q == $past(wr_data));
        end
    end

    assign rd_data = regs_o[rd_idx*8 +: 8];
endmodule

// File: rtl/smbus_blk_slave.sv
module smbus_blk_slave
    import smbus_blk_pkg::*;
#(
    parameter int                   REG_COUNT = 16,
    parameter int                   STRAP_W   = 2,
    parameter logic [6:0]           BASE_ADDR = 7'h6A,
    parameter int                   CNT_IDX   = 8,
    parameter logic [7:0]           CNT_RST   = 8'h02,
    parameter logic [REG_COUNT-1:0] RO_MASK   = 16'hC000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [STRAP_W-1:0]     strap_i,
    output logic                   sda_oe_o,
    output logic [REG_COUNT*8-1:0] regs_o
);
    localparam int IDX_W = $clog2(REG_COUNT);
    localparam logic [IDX_W-1:0] IDX_ONE = 1;

    typedef struct packed {
        bus_st_e          st;
        byte_ph_e         ph;
        logic [2:0]       bitc;
        logic [7:0]       sh;
        logic             oe;
        logic             ack;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] base;
        logic [7:0]       remain;
    } slv_t;

    slv_t s_d, s_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [7:0] rd_data, cnt_val, byte_in;
    logic [6:0] my_addr;

    smbus_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    smbus_reg_bank #(
        .REG_COUNT(REG_COUNT),
        .IDX_W    (IDX_W),
        .CNT_IDX  (CNT_IDX),
        .CNT_RST  (CNT_RST),
        .RO_MASK  (RO_MASK)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (s_q.idx),
        .wr_data(byte_in),
        .rd_idx (s_q.idx),
        .rd_data(rd_data),
        .regs_o (regs_o)
    );

    assign my_addr = {BASE_ADDR[6:STRAP_W], strap_i};
    assign cnt_val = regs_o[CNT_IDX*8 +: 8];
    assign byte_in = {s_q.sh[6:0], sda_i};

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        if (start_det) begin
            s_d.st   = S_RX;
            s_d.ph   = P_ADDR;
            s_d.bitc = 3'd0;
            s_d.oe   = 1'b0;
        end else if (stop_det) begin
            s_d.st = S_IDLE;
            s_d.oe = 1'b0;
        end else begin
            unique case (s_q.st)
                S_RX: if (scl_rise) begin
                    s_d.sh   = byte_in;
                    s_d.bitc = s_q.bitc + 3'd1;
                    if (s_q.bitc == 3'd7) begin
                        s_d.st   = S_ACK_SETUP;
                        s_d.ack  = 1'b1;
                        s_d.bitc = 3'd0;
                        unique case (s_q.ph)
                            P_ADDR: begin
                                if (byte_in[7:1] != my_addr) s_d.st = S_IGNORE;
                                else if (byte_in[0])         s_d.ph = P_TXSTART;
                                else                         s_d.ph = P_IDX;
                            end
                            P_IDX: begin
                                s_d.idx  = byte_in[IDX_W-1:0];
                                s_d.base = byte_in[IDX_W-1:0];
                                s_d.ph   = P_CNT;
                            end
                            P_CNT: begin
                                s_d.remain = byte_in;
                                s_d.ph     = P_DATA;
                            end
                            P_DATA: begin
                                if (s_q.remain != 8'd0) begin
                                    wr_en      = 1'b1;
                                    s_d.idx    = s_q.idx + IDX_ONE;
                                    s_d.remain = s_q.remain - 8'd1;
                                end else begin
                                    s_d.ack = 1'b0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_ACK_SETUP: if (scl_fall) begin
                    s_d.oe = s_q.ack;
                    s_d.st = S_ACK_HOLD;
                end
                S_ACK_HOLD: if (scl_fall) begin
                    s_d.bitc = 3'd0;
                    if (!s_q.ack) begin
                        s_d.oe = 1'b0;
                        s_d.st = S_IGNORE;
                    end else if (s_q.ph == P_TXSTART) begin
                        s_d.sh  = cnt_val;
                        s_d.oe  = ~cnt_val[7];
                        s_d.idx = s_q.base;
                        s_d.st  = S_TX;
                    end else begin
                        s_d.oe = 1'b0;
                        s_d.st = S_RX;
                    end
                end
                S_TX: if (scl_fall) begin
                    if (s_q.bitc == 3'd7) begin
                        s_d.oe = 1'b0;
                        s_d.st = S_TX_ACK;
                    end else begin
                        s_d.bitc = s_q.bitc + 3'd1;
                        s_d.sh   = {s_q.sh[6:0], 1'b0};
                        s_d.oe   = ~s_q.sh[6];
                    end
                end
                S_TX_ACK: if (scl_rise) begin
                    if (!sda_i) begin
                        s_d.sh  = rd_data;
                        s_d.idx = s_q.idx + IDX_ONE;
                        s_d.st  = S_TX_WAIT;
                    end else begin
                        s_d.st = S_IGNORE;
                    end
                end
                S_TX_WAIT: if (scl_fall) begin
                    s_d.oe   = ~s_q.sh[7];
                    s_d.bitc = 3'd0;
                    s_d.st   = S_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, ph: P_ADDR, bitc: 3'd0, sh: 8'd0, oe: 1'b0,
                     ack: 1'b0, idx: '0, base: '0, remain: 8'd0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe_o = s_q.oe;

    // R10
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R4
    remain_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.remain == $past(s_q.remain) - 8'd1);

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_IGNORE) && !start_det |=> !sda_oe_o);
endmodule

// File: tb/tb_smbus_blk_slave.sv
`timescale 1ns/1ps
module tb_smbus_blk_slave;
    localparam int Q = 4;

    typedef struct {
        string      req;
        logic [7:0] v;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_h = 1'b1;
    logic [1:0]   strap = 2'b10;
    logic         oe;
    logic         sda_line;
    logic [127:0] regs;

    int checks = 0;
    int fails = 0;
    int edge_viol = 0;
    bit oe_seen = 0;
    logic prev_oe = 1'b0;
    logic [7:0] model [16];
    int   tb_base = 0;
    logic [7:0] dq [$];
    exp_t exp_q [$];
    logic [7:0] obs_q [$];

    assign sda_line = sda_h & ~oe;

    smbus_blk_slave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .strap_i (strap),
        .sda_oe_o(oe),
        .regs_o  (regs)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0 && obs_q.size() > 0) begin
            exp_t e;
            logic [7:0] o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            chk(e.req, int'(o), int'(e.v));
        end
        if (oe) oe_seen = 1;
        if (oe !== prev_oe && scl) edge_viol++;
        prev_oe = oe;
    end

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wt(Q); scl = 1'b1; wt(Q);
        sda_h = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_h = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_h = 1'b1; wt(Q); scl = 1'b1; wt(Q);
        ack = !sda_line;
        wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic rd_byte(input logic nack);
        logic [7:0] b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl = 1'b1; wt(Q);
            b = {b[6:0], sda_line};
            wt(Q); scl = 1'b0; wt(2*Q);
        end
        obs_q.push_back(b);
        sda_h = nack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
        sda_h = 1'b1;
    endtask

    function automatic bit is_ro(input int p);
        return p >= 14;
    endfunction

    task automatic cmp_regs(input string req);
        for (int i = 0; i < 16; i++) chk(req, int'(regs[i*8 +: 8]), int'(model[i]));
    endtask

    // block write of dq with announced count cnt
    task automatic blk_write(input logic [7:0] a, input int idx, input int cnt,
                             input bit match, input string req);
        logic ack;
        bus_start();
        wr_byte(a, ack);             chk({req, " addr ack"}, ack, match);
        wr_byte(8'(idx), ack);       chk({req, " idx ack"}, ack, match);
        if (match) tb_base = idx % 16;
        wr_byte(8'(cnt), ack);       chk({req, " cnt ack"}, ack, match);
        for (int k = 0; k < dq.size(); k++) begin
            bit ok = match && (k < cnt);
            wr_byte(dq[k], ack);
            chk({req, " data ack"}, ack, ok);
            if (ok && !is_ro((idx + k) % 16)) model[(idx + k) % 16] = dq[k];
        end
        bus_stop();
    endtask

    // block read of n bytes after the count byte
    task automatic blk_read(input int idx, input int n, input bit with_idx, input string req);
        logic ack;
        bus_start();
        if (with_idx) begin
            wr_byte(8'hD4, ack);     chk({req, " addr ack"}, ack, 1);
            wr_byte(8'(idx), ack);   chk({req, " idx ack"}, ack, 1);
            tb_base = idx % 16;
            sda_h = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_h = 1'b0; wt(Q); scl = 1'b0; wt(Q);
        end
        wr_byte(8'hD5, ack);         chk({req, " raddr ack"}, ack, 1);
        exp_q.push_back('{req: {req, " count"}, v: model[8]});
        rd_byte(1'b0);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back('{req: {req, " data"}, v: model[(tb_base + k) % 16]});
            rd_byte(k == n - 1);
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        for (int i = 0; i < 16; i++) model[i] = is_ro(i) ? (8'hA0 | 8'(i)) : 8'h00;
        model[8] = 8'h02;
        wt(5); rst_n = 1'b1; wt(5);

        // R9 reset state, R8 read-only contents
        chk("R9 oe", oe, 0);
        chk("R9 count reg", int'(regs[8*8 +: 8]), 8'h02);
        chk("R9 reg0", int'(regs[7:0]), 0);
        chk("R8 reg14", int'(regs[14*8 +: 8]), 8'hAE);
        chk("R8 reg15", int'(regs[15*8 +: 8]), 8'hAF);

        // R1 R3 plain block write
        dq = '{8'h11, 8'h22, 8'h33, 8'h44};
        blk_write(8'hD4, 3, 4, 1, "R3");
        cmp_regs("R3 bank");

        // R6 block read with index phase
        blk_read(3, 5, 1, "R6");

        // R11 count register write, then read returns it
        dq = '{8'h05};
        blk_write(8'hD4, 8, 1, 1, "R11");
        blk_read(3, 2, 1, "R11 read");

        // R5 wrap and R8 read-only targets
        dq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
        blk_write(8'hD4, 8'h1E, 4, 1, "R5");
        cmp_regs("R5 bank");
        chk("R8 reg15 kept", int'(regs[15*8 +: 8]), 8'hAF);

        // R4 byte beyond the count
        dq = '{8'h77, 8'h88};
        blk_write(8'hD4, 10, 1, 1, "R4");
        cmp_regs("R4 bank");

        // R2 address mismatch
        oe_seen = 0;
        dq = '{8'h99, 8'h98};
        blk_write(8'hD0, 2, 2, 0, "R2");
        chk("R2 no drive", oe_seen, 0);
        cmp_regs("R2 bank");

        // R1 strap selects another address
        strap = 2'b01; wt(2);
        dq = '{8'h5A};
        blk_write(8'hD2, 2, 1, 1, "R1 strap");
        cmp_regs("R1 bank");
        strap = 2'b10; wt(2);

        // R7 read without index phase
        dq = '{8'h66};
        blk_write(8'hD4, 5, 1, 1, "R7 setup");
        blk_read(0, 2, 0, "R7");

        // R10 stop in the middle of a data byte
        bus_start();
        wr_byte(8'hD4, ack); wr_byte(8'h00, ack); wr_byte(8'h01, ack);
        tb_base = 0;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R10 released", oe, 0);
        cmp_regs("R10 bank");
        blk_read(0, 2, 1, "R10 recover");

        wt(20);
        chk("R10 scoreboard drained", exp_q.size() + obs_q.size(), 0);
        chk("R10 sda edges", edge_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule